// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 31 on-chip peripherals and turns them into one request toward the host processor. Pending requests are remembered in a pending register, filtered by a per-source enable mask, and ranked. The winner is presented on one output line, chosen from eight processor interrupt levels by a programmable field. The processor learns which source won by setting an acknowledge bit in the vector register and reading the five-bit source code back from the top of that register's low half-word. It then retires the source by writing a one to its pending bit.

The ranking is fixed by source number, with the higher number winning. Two programmable parts change it: a single source can be promoted above all others, and the four serial-channel sources (28 to 31) can be permuted among the four top priority slots. Source code 0 is reserved. The controller returns it when an acknowledge finds nothing eligible, for instance because software masked the source after the request line went up, and it pulses a separate error output in that case. Retiring a code-0 acknowledge needs no further action.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x000000E4 (enable off, level 0, no promoted source, slot k holds channel k). The mask, pending and vector words read 0, the request output is 0 and the error output is low.
- R2: Word address 0 is configuration, 1 is mask, 2 is pending and 3 is vector. Configuration bits are: [1:0],[3:2],[5:4],[7:6] give the channel for slots 0..3; [12:8] is the promoted source; [15:13] is the request level; [16] is the global enable. Other configuration bits read 0. The mask reads back as written.
- R3: A source held high at a clock edge sets its pending bit at that edge. A pending bit stays set until a pending-word write with a 1 in that bit. Writing 0 leaves the bit alone. A source that is high during the clearing write stays pending. Source 0 never becomes pending.
- R4: The request output is one-hot, with bit L set for level L, one cycle after global enable is on and at least one pending source has its mask bit at 1. Otherwise it is all zero. A mask bit of 0 disables that source.
- R5: Among eligible sources (pending and unmasked), the highest source number wins, apart from R6 and R7.
- R6: When the promoted-source field is non-zero and that source is eligible, it wins over all others.
- R7: Priority ranks 28..31 are slots 0..3. Slot k serves source 28+c, where c is the channel in field k. The highest slot holding an eligible channel ranks above sources 0..27.
- R8: Writing the vector word with bit 0 = 1 latches the winner's code into bits 15:11. Bit 0 then reads 1 for exactly one cycle. The code is held until the next acknowledge. A vector write with bit 0 = 0 changes nothing.
- R9: An acknowledge that finds global enable off or nothing eligible latches code 0 and pulses the error output high for one cycle. The next acknowledge with an eligible source returns that source normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for bus_sel |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_req | input | 32 | Level-sensitive source requests; bit 0 unused |
| cpu_irq | output | 8 | One-hot request to the processor, bit = level |
| race_err | output | 1 | One-cycle pulse when an acknowledge yields code 0 |

## Verification
The bench targets the permutation of the serial slots with a reordering under which a default-order arbiter would return 30 instead of 29. It also checks a promoted source that is not pending, which a careless override would return anyway. Masking a source after it is presented and then acknowledging must give code 0 and the error pulse; a design that uses a stale winner returns 5 instead. Clearing writes are tried with zero data, with the source low and with the source still high, to catch a pending register that drops live requests or ignores the write-one rule.

// File: rtl/pirq_pkg.sv
// Package: register word addresses and configuration field positions
// shared by the interrupt controller modules.
package pirq_pkg;
    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_MASK = 2'd1,
        REG_PEND = 2'd2,
        REG_VEC  = 2'd3
    } reg_word_e;

    localparam int CFG_ORD_LSB = 0;
    localparam int CFG_HP_LSB  = 8;
    localparam int CFG_LVL_LSB = 13;
    localparam int CFG_GIE_BIT = 16;
    localparam int VEC_HALF_W  = 16;
endpackage

// File: rtl/pirq_pend.sv
// Pending register. Each bit is set while its level-sensitive source is
// high and cleared only by a write-one-to-clear. When set and clear meet
// in one cycle, set wins. Assumes source bit 0 is reserved.
module pirq_pend #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] clr_w1c,
    output logic [NUM_SRC-1:0] pend_q
);
    localparam logic [NUM_SRC-1:0] SRC_USE = {{(NUM_SRC-1){1'b1}}, 1'b0};

    // Update pending bits: clear on write-one, then merge live levels.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_w1c) | (src_req & SRC_USE);
    end

    // A bit written with one while its source was low must be clear now.
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & $past(clr_w1c & ~src_req)) == '0);
    // A live source is always captured at the next edge.
    p_level_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & $past(src_req & SRC_USE)) == $past(src_req & SRC_USE));
endmodule

// File: rtl/pirq_arb.sv
// Arbiter: ranks eligible sources by number, with the four serial
// channels permuted into the top four ranks and an optional promoted
// source that overrides the ranking. Purely combinational.
module pirq_arb #(
    parameter int NUM_SRC = 32,
    parameter int CHAN_N  = 4,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int ORD_W   = $clog2(CHAN_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       elig,
    input  logic [ID_W-1:0]          hp_id,
    input  logic [CHAN_N*ORD_W-1:0]  ord,
    output logic [ID_W-1:0]          win_id,
    output logic                     win_any
);
    localparam int SER_BASE = NUM_SRC - CHAN_N;

    logic [ID_W-1:0]    rank_id [NUM_SRC];
    logic [NUM_SRC-1:0] rank_req;
    logic [ID_W-1:0]    pick;
    logic               found;
    logic               hp_ok;

    for (genvar p = 0; p < NUM_SRC; p++) begin : g_rank
        if (p >= SER_BASE) begin : g_ser
            logic [ORD_W-1:0] ch;
            assign ch         = ord[(p-SER_BASE)*ORD_W +: ORD_W];
            assign rank_id[p] = ID_W'(SER_BASE) + ID_W'(ch);
        end else begin : g_plain
            assign rank_id[p] = ID_W'(p);
        end
        assign rank_req[p] = elig[rank_id[p]];
    end

    // Highest occupied rank wins; later loop iterations override earlier.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int p = 0; p < NUM_SRC; p++) begin
            if (rank_req[p]) begin
                pick  = rank_id[p];
                found = 1'b1;
            end
        end
    end

    // Apply the promoted-source override when it is eligible.
    always_comb begin
        hp_ok   = (hp_id != '0) && elig[hp_id];
        win_id  = hp_ok ? hp_id : pick;
        win_any = found;
    end

    // The reported winner is always an eligible source.
    p_win_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_any |-> elig[win_id]);
    // No winner only when nothing is eligible.
    p_none_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !win_any |-> (elig == '0));
endmodule

// File: rtl/pirq_regs.sv
// Register file: configuration, mask, write-one-to-clear strobe for the
// pending word, and the vector latch with its self-clearing acknowledge.
// Assumes ID_W <= 5 so the code fits bits 15:11 of the vector word.
module pirq_regs
    import pirq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int CHAN_N  = 4,
    parameter int LVL_W   = 3,
    parameter int DATA_W  = 32,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int ORD_W   = $clog2(CHAN_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [1:0]              bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NUM_SRC-1:0]      pend_q,
    input  logic [ID_W-1:0]         win_id,
    input  logic                    win_any,
    output logic [NUM_SRC-1:0]      mask_q,
    output logic                    gie_q,
    output logic [LVL_W-1:0]        lvl_q,
    output logic [ID_W-1:0]         hp_q,
    output logic [CHAN_N*ORD_W-1:0] ord_q,
    output logic [NUM_SRC-1:0]      pend_clr,
    output logic                    race_err
);
    localparam int OW = CHAN_N * ORD_W;
    localparam int PAD_W = VEC_HALF_W - ID_W - 1;

    logic            wr;
    logic            ack_wr;
    logic            ack_q;
    logic [ID_W-1:0] code_q;
    logic [OW-1:0]   ord_init;

    for (genvar k = 0; k < CHAN_N; k++) begin : g_ord_init
        assign ord_init[k*ORD_W +: ORD_W] = ORD_W'(k);
    end

    // Decode the write strobes.
    always_comb begin
        wr       = bus_sel && bus_we;
        ack_wr   = wr && (bus_addr == REG_VEC) && bus_wdata[0];
        pend_clr = (wr && bus_addr == REG_PEND) ? bus_wdata[NUM_SRC-1:0] : '0;
    end

    // Configuration word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            lvl_q <= '0;
            hp_q  <= '0;
            ord_q <= ord_init;
        end else if (wr && bus_addr == REG_CFG) begin
            gie_q <= bus_wdata[CFG_GIE_BIT];
            lvl_q <= bus_wdata[CFG_LVL_LSB +: LVL_W];
            hp_q  <= bus_wdata[CFG_HP_LSB +: ID_W];
            ord_q <= bus_wdata[CFG_ORD_LSB +: OW];
        end
    end

    // Mask word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                            mask_q <= '0;
        else if (wr && bus_addr == REG_MASK)   mask_q <= bus_wdata[NUM_SRC-1:0];
    end

    // Vector latch, one-cycle acknowledge flag and race pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            ack_q    <= 1'b0;
            race_err <= 1'b0;
        end else begin
            ack_q    <= ack_wr;
            race_err <= ack_wr && !(gie_q && win_any);
            if (ack_wr) code_q <= (gie_q && win_any) ? win_id : '0;
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            REG_CFG:  bus_rdata = DATA_W'({gie_q, lvl_q, hp_q, ord_q});
            REG_MASK: bus_rdata = DATA_W'(mask_q);
            REG_PEND: bus_rdata = DATA_W'(pend_q);
            default:  bus_rdata = DATA_W'({code_q, {PAD_W{1'b0}}, ack_q});
        endcase
    end

    // Acknowledge flag only follows an acknowledge write.
    p_ack_selfclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> $past(ack_wr));
    // Latched code only moves on an acknowledge.
    p_code_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack_wr) |-> $stable(code_q));
    // A race pulse always comes with the reserved code.
    p_race_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        race_err |-> (code_q == '0));
endmodule

// File: rtl/pirq_ctrl.sv
// Top: vectored peripheral interrupt controller. Joins the pending
// register, the arbiter and the register file, and drives the one-hot
// processor request at the programmed level, registered one cycle.
module pirq_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int CHAN_N  = 4,
    parameter int LVL_W   = 3,
    parameter int DATA_W  = 32,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int ORD_W   = $clog2(CHAN_N),
    parameter int IRQ_N   = 1 << LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [1:0]         bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic [IRQ_N-1:0]   cpu_irq,
    output logic               race_err
);
    logic [NUM_SRC-1:0]      pend_q, mask_q, pend_clr, elig;
    logic                    gie_q, win_any;
    logic [LVL_W-1:0]        lvl_q;
    logic [ID_W-1:0]         hp_q, win_id;
    logic [CHAN_N*ORD_W-1:0] ord_q;

    pirq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .clr_w1c(pend_clr), .pend_q(pend_q)
    );

    assign elig = pend_q & mask_q;

    pirq_arb #(.NUM_SRC(NUM_SRC), .CHAN_N(CHAN_N), .ID_W(ID_W), .ORD_W(ORD_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .elig(elig), .hp_id(hp_q), .ord(ord_q),
        .win_id(win_id), .win_any(win_any)
    );

    pirq_regs #(.NUM_SRC(NUM_SRC), .CHAN_N(CHAN_N), .LVL_W(LVL_W), .DATA_W(DATA_W),
                .ID_W(ID_W), .ORD_W(ORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_q(pend_q), .win_id(win_id), .win_any(win_any),
        .mask_q(mask_q), .gie_q(gie_q), .lvl_q(lvl_q), .hp_q(hp_q),
        .ord_q(ord_q), .pend_clr(pend_clr), .race_err(race_err)
    );

    // Drive the request line at the programmed level.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cpu_irq <= '0;
        else if (gie_q && win_any)  cpu_irq <= IRQ_N'(1) << lvl_q;
        else                        cpu_irq <= '0;
    end

    // Never more than one level asserted.
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_irq));
    // A request only follows an enabled, eligible cycle.
    p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |-> $past(gie_q && (elig != '0)));
endmodule

// File: tb/sim_pirq_ctrl.sv
module sim_pirq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] src_req = '0;
    logic [7:0]  cpu_irq;
    logic        race_err;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    pirq_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_req(src_req), .cpu_irq(cpu_irq), .race_err(race_err));

    // {src, mask, cfg, code, irq}
    localparam logic [108:0] TBL [12] = '{
        {32'h0000_0006, 32'hFFFF_FFFF, 32'h0001_00E4, 5'd2,  8'h01},
        {32'h0000_0410, 32'hFFFF_FFFF, 32'h0001_A0E4, 5'd10, 8'h20},
        {32'h0000_0410, 32'hFFFF_FBFF, 32'h0001_60E4, 5'd4,  8'h08},
        {32'h0000_0410, 32'hFFFF_FFFF, 32'h0001_04E4, 5'd4,  8'h01},
        {32'h0000_0010, 32'hFFFF_FFFF, 32'h0001_09E4, 5'd4,  8'h01},
        {32'hF000_0000, 32'hFFFF_FFFF, 32'h0001_00E4, 5'd31, 8'h01},
        {32'hF000_0000, 32'hFFFF_FFFF, 32'h0001_001B, 5'd28, 8'h01},
        {32'h6000_0000, 32'hFFFF_FFFF, 32'h0001_001B, 5'd29, 8'h01},
        {32'h1800_0000, 32'hFFFF_FFFF, 32'h0001_E0E4, 5'd28, 8'h80},
        {32'h0000_0004, 32'hFFFF_FFFF, 32'h0000_00E4, 5'd0,  8'h00},
        {32'h0000_0008, 32'h0000_0000, 32'h0001_00E4, 5'd0,  8'h00},
        {32'h0000_0001, 32'hFFFF_FFFF, 32'h0001_00E4, 5'd0,  8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 cfg", v, 32'h0000_00E4);
        rd(2'd1, v); chk("R1 mask", v, 32'h0);
        rd(2'd2, v); chk("R1 pend", v, 32'h0);
        rd(2'd3, v); chk("R1 vec", v, 32'h0);
        chk("R1 irq", {24'h0, cpu_irq}, 32'h0);
        chk("R1 err", {31'h0, race_err}, 32'h0);

        // R2 field readback
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R2 cfg bits", v, 32'h0001_FFFF);
        wr(2'd1, 32'hA5A5_5A5A); rd(2'd1, v); chk("R2 mask rb", v, 32'hA5A5_5A5A);

        // Table walk: R4 R5 R6 R7 R9
        for (int i = 0; i < 12; i++) begin
            logic [31:0] t_src, t_mask, t_cfg;
            logic [4:0]  t_code;
            logic [7:0]  t_irq;
            {t_src, t_mask, t_cfg, t_code, t_irq} = TBL[i];
            @(negedge clk); src_req = t_src;
            wr(2'd1, t_mask);
            wr(2'd0, t_cfg);
            idle(1);
            chk($sformatf("R4 irq level row%0d", i), {24'h0, cpu_irq}, {24'h0, t_irq});
            wr(2'd3, 32'h1);
            chk($sformatf("R9 err row%0d", i), {31'h0, race_err}, {31'h0, t_code == 5'd0});
            rd(2'd3, v);
            chk($sformatf("R5 R6 R7 code row%0d", i), v, {16'h0, t_code, 10'h0, 1'b1});
            src_req = '0;
            wr(2'd2, 32'hFFFF_FFFF);
            rd(2'd2, v); chk($sformatf("R3 cleared row%0d", i), v, 32'h0);
        end

        // R3 pending behaviour
        wr(2'd0, 32'h0000_00E4);
        @(negedge clk); src_req = 32'h80;
        idle(1);
        src_req = '0;
        rd(2'd2, v); chk("R3 captured", v, 32'h80);
        wr(2'd2, 32'h0); rd(2'd2, v); chk("R3 write0 no effect", v, 32'h80);
        wr(2'd2, 32'h80); rd(2'd2, v); chk("R3 w1c", v, 32'h0);
        src_req = 32'h80;
        wr(2'd2, 32'h80); rd(2'd2, v); chk("R3 set wins", v, 32'h80);
        src_req = 32'h1; idle(2);
        wr(2'd2, 32'h80); rd(2'd2, v); chk("R3 src0 ignored", v, 32'h0);
        src_req = '0;

        // R8 acknowledge and hold
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0001_00E4);
        src_req = 32'h80; idle(1);
        wr(2'd3, 32'h1);
        rd(2'd3, v); chk("R8 ack code", v, {16'h0, 5'd7, 11'h001});
        idle(1);
        rd(2'd3, v); chk("R8 ack selfclear", v, {16'h0, 5'd7, 11'h000});
        src_req = 32'h280; idle(2);
        rd(2'd3, v); chk("R8 code held", v, {16'h0, 5'd7, 11'h000});
        wr(2'd3, 32'h0);
        rd(2'd3, v); chk("R8 write0 no ack", v, {16'h0, 5'd7, 11'h000});
        wr(2'd3, 32'h1);
        rd(2'd3, v); chk("R8 new code", v, {16'h0, 5'd9, 11'h001});
        src_req = '0;
        wr(2'd2, 32'hFFFF_FFFF);

        // R9 mask while presented
        src_req = 32'h20; idle(2);
        chk("R4 presented", {24'h0, cpu_irq}, 32'h01);
        wr(2'd1, 32'h0); idle(1);
        chk("R4 masked drops", {24'h0, cpu_irq}, 32'h0);
        wr(2'd3, 32'h1);
        chk("R9 race pulse", {31'h0, race_err}, 32'h1);
        rd(2'd3, v); chk("R9 race code", v, 32'h0000_0001);
        idle(1);
        chk("R9 pulse ends", {31'h0, race_err}, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd3, 32'h1);
        chk("R9 no err after", {31'h0, race_err}, 32'h0);
        rd(2'd3, v); chk("R9 recovers", v, {16'h0, 5'd5, 11'h001});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule